// File: doc/BRIEF.md
# Code Boundary Servo Controller

This block steers the analog input of a converter under test onto the decision level that separates a chosen target code from the code one below it. For every accepted output word it performs a magnitude test against the target. A word below the target commands a charge step toward an external integrator, and any other word commands a discharge step. The two pulses are mutually exclusive and are held until the next accepted word. A digital integrator inside the block follows the same steps in units of one tenth of an LSB. Its value therefore tracks the voltage the analog loop builds up, and each step moves it by one unit.

Once the loop hovers at the decision level, the output alternates between the target code and its lower neighbour. The block recognises this from a run of direction reversals and raises a settled flag. While the flag is high it sums the integrator value over a block of accepted samples. It then publishes the mean together with a one-cycle strobe, so that the kick-back glitches around individual conversions are averaged away.

If the integrator is pinned at either end of its range and is still being pushed outward, the target cannot be reached and an out-of-range flag is raised. Changing the target restarts settle detection and averaging. The integrator keeps its value, so the loop continues from where it stood.

Top module: `boundary_servo`

## Requirements
- R1: `code_ready` is low during reset, goes high at the first clock edge after reset is released, and then stays high. A code word is accepted only in a cycle with both `code_valid` and `code_ready` high.
- R2: Both drive outputs are low after reset. On an accepted word, `charge_up`=1 and `charge_dn`=0 follow if the word is numerically below `target_code`; otherwise `charge_dn`=1 and `charge_up`=0 follow. Both values hold until the next accepted word.
- R3: `integ_level` is 0 after reset. An accepted charge word raises it by exactly 1, and an accepted discharge word lowers it by exactly 1. Ten units equal one LSB.
- R4: `integ_level` saturates at 0 and at 2^CODE_W*10-1 (2559 by default) and never leaves that range.
- R5: `out_of_range` is set when an accepted word asks for a step beyond a saturation limit (charge at 2559, or discharge at 0). It stays set until the target changes or reset is applied.
- R6: `settled` goes high once 16 direction reversals have been accepted with no same-direction run longer than 4 steps. A fifth consecutive step in one direction clears the reversal count and drops `settled` at that edge.
- R7: While `settled` is high, each accepted word adds the pre-step `integ_level` to a sum. After 1024 such samples, `mean_level` receives floor(sum/1024) and `mean_valid` pulses for exactly one cycle, and a new block begins. If `settled` drops, the partial sum is discarded.
- R8: A change of `target_code` clears `settled`, `out_of_range` and the partial sum at the clock edge where the change is first seen.
- R9: A cycle without an accepted word leaves `integ_level`, `charge_up` and `charge_dn` unchanged.
- R10: With a monotonic converter whose code is floor((level+offset)/10), the settled loop hovers so that every output word is the target or the target minus one. The reported mean is then 10*target-offset-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| target_code | input | CODE_W | Code whose lower decision level is sought |
| code_valid | input | 1 | Converter word present |
| code_ready | output | 1 | Block accepts a word this cycle |
| code_data | input | CODE_W | Converter output word |
| charge_up | output | 1 | Enable the charging current path |
| charge_dn | output | 1 | Enable the discharging current path |
| integ_level | output | INT_W | Digital integrator in tenth-LSB units |
| settled | output | 1 | Loop is hovering at the decision level |
| out_of_range | output | 1 | Target unreachable, integrator pinned |
| mean_level | output | INT_W | Averaged integrator value |
| mean_valid | output | 1 | One-cycle strobe for a new mean |

## Verification
The assertions assume that the target is held steady except where a deliberate change is meant to restart the loop. They also assume that words arrive only through the valid/ready handshake, so that every integrator change traces back to an accepted cycle. The stimulus derives each converter word from the integrator through a monotonic model with a fixed offset. It changes that offset or the target only between measurement phases, and it uses a stuck low or high word to drive the integrator deliberately into either limit.

// File: rtl/servo_pkg.sv
package servo_pkg;
  typedef enum logic {
    STEP_DOWN = 1'b0,
    STEP_UP   = 1'b1
  } step_dir_e;

  function automatic int unsigned level_max(input int unsigned code_w,
                                            input int unsigned sub_per_lsb);
    return (32'd1 << code_w) * sub_per_lsb - 1;
  endfunction
endpackage

// File: rtl/servo_steer.sv
module servo_steer
  import servo_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int LVL_MAX = 2559,
  parameter int INT_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] target,
  output step_dir_e         dir_o,
  output logic              up_o,
  output logic              dn_o,
  output logic [INT_W-1:0]  level_o,
  output logic              oor_o
);
  localparam logic [INT_W-1:0] TOP = INT_W'(LVL_MAX);

  logic at_top, at_bot, pinned;

  always_comb begin
    dir_o  = (code < target) ? STEP_UP : STEP_DOWN;
    at_top = (level_o == TOP);
    at_bot = (level_o == '0);
    pinned = (dir_o == STEP_UP) ? at_top : at_bot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_o <= '0;
      up_o    <= 1'b0;
      dn_o    <= 1'b0;
      oor_o   <= 1'b0;
    end else begin
      if (accept) begin
        up_o <= (dir_o == STEP_UP);
        dn_o <= (dir_o == STEP_DOWN);
        if (!pinned) begin
          if (dir_o == STEP_UP) level_o <= level_o + 1'b1;
          else                  level_o <= level_o - 1'b1;
        end
      end
      if (restart)               oor_o <= 1'b0;
      else if (accept && pinned) oor_o <= 1'b1;
    end
  end

  assert_one_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ($countones({up_o, dn_o}) == 1));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(level_o) && $stable(up_o) && $stable(dn_o)));

  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (level_o == $past(level_o) + 1'b1 || level_o == $past(level_o) - 1'b1
                || $stable(level_o)));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= TOP);

  assert_oor_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oor_o) |-> ($past(level_o) == TOP || $past(level_o) == '0));
endmodule

// File: rtl/servo_settle.sv
module servo_settle
  import servo_pkg::*;
#(
  parameter int REV_N   = 16,
  parameter int RUN_MAX = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      restart,
  input  step_dir_e dir,
  output logic      settled_o
);
  localparam int REV_W = $clog2(REV_N + 1);
  localparam int RUN_W = $clog2(RUN_MAX + 2);
  localparam logic [REV_W-1:0] REV_FULL = REV_W'(REV_N);
  localparam logic [RUN_W-1:0] RUN_LIM  = RUN_W'(RUN_MAX);

  logic [REV_W-1:0] rev_cnt;
  logic [RUN_W-1:0] run_cnt;
  logic             have_prev;
  step_dir_e        prev_dir;
  logic             flips, run_over;

  always_comb begin
    flips     = have_prev && (dir != prev_dir);
    run_over  = have_prev && !flips && (run_cnt >= RUN_LIM);
    settled_o = (rev_cnt == REV_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      rev_cnt   <= '0;
      run_cnt   <= '0;
      have_prev <= 1'b0;
      prev_dir  <= STEP_DOWN;
    end else if (accept) begin
      have_prev <= 1'b1;
      prev_dir  <= dir;
      if (flips) begin
        run_cnt <= RUN_W'(1);
        if (rev_cnt != REV_FULL) rev_cnt <= rev_cnt + 1'b1;
      end else if (!have_prev) begin
        run_cnt <= RUN_W'(1);
      end else begin
        if (run_cnt <= RUN_LIM) run_cnt <= run_cnt + 1'b1;
        if (run_over) rev_cnt <= '0;
      end
    end
  end

  assert_settle_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled_o) |-> $past(accept));

  assert_long_run_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && run_over && !restart) |=> !settled_o);
endmodule

// File: rtl/servo_average.sv
module servo_average #(
  parameter int INT_W    = 12,
  parameter int AVG_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             restart,
  input  logic             settled,
  input  logic [INT_W-1:0] level,
  output logic [INT_W-1:0] mean_o,
  output logic             mean_valid_o
);
  localparam int ACC_W = INT_W + AVG_LOG2;

  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    sum_next;
  logic [AVG_LOG2-1:0] cnt;

  assign sum_next = acc + ACC_W'(level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc          <= '0;
      cnt          <= '0;
      mean_o       <= '0;
      mean_valid_o <= 1'b0;
    end else if (restart || !settled) begin
      acc          <= '0;
      cnt          <= '0;
      mean_valid_o <= 1'b0;
    end else if (accept) begin
      if (&cnt) begin
        mean_o       <= sum_next[ACC_W-1:AVG_LOG2];
        mean_valid_o <= 1'b1;
        acc          <= '0;
        cnt          <= '0;
      end else begin
        acc          <= sum_next;
        cnt          <= cnt + 1'b1;
        mean_valid_o <= 1'b0;
      end
    end else begin
      mean_valid_o <= 1'b0;
    end
  end

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mean_valid_o |=> !mean_valid_o);

  assert_strobe_needs_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mean_valid_o) |-> $past(settled && accept));
endmodule

// File: rtl/boundary_servo.sv
module boundary_servo
  import servo_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SUB_PER_LSB = 10,
  parameter int REV_N       = 16,
  parameter int RUN_MAX     = 4,
  parameter int AVG_LOG2    = 10,
  localparam int LVL_MAX    = int'(level_max(CODE_W, SUB_PER_LSB)),
  localparam int INT_W      = $clog2(LVL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] target_code,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code_data,
  output logic              charge_up,
  output logic              charge_dn,
  output logic [INT_W-1:0]  integ_level,
  output logic              settled,
  output logic              out_of_range,
  output logic [INT_W-1:0]  mean_level,
  output logic              mean_valid
);
  logic [CODE_W-1:0] tgt_q;
  logic              accept, restart;
  step_dir_e         dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_ready <= 1'b0;
      tgt_q      <= '0;
    end else begin
      code_ready <= 1'b1;
      tgt_q      <= target_code;
    end
  end

  assign accept  = code_valid && code_ready;
  assign restart = (target_code != tgt_q);

  servo_steer #(.CODE_W(CODE_W), .LVL_MAX(LVL_MAX), .INT_W(INT_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .restart(restart),
    .code(code_data), .target(target_code), .dir_o(dir),
    .up_o(charge_up), .dn_o(charge_dn), .level_o(integ_level), .oor_o(out_of_range)
  );

  servo_settle #(.REV_N(REV_N), .RUN_MAX(RUN_MAX)) u_settle (
    .clk(clk), .rst_n(rst_n), .accept(accept), .restart(restart),
    .dir(dir), .settled_o(settled)
  );

  servo_average #(.INT_W(INT_W), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .accept(accept), .restart(restart),
    .settled(settled), .level(integ_level),
    .mean_o(mean_level), .mean_valid_o(mean_valid)
  );

  assert_ready_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    code_ready |=> code_ready);

  assert_retarget_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_ready && restart) |=> (!settled && !out_of_range));
endmodule

// File: tb/tb_boundary_servo.sv
module tb_boundary_servo;
  localparam int CW = 8;
  localparam int IW = 12;

  typedef struct packed {
    int tgt;
    int off;
    int mean;
  } vec_t;

  localparam vec_t TV [4] = '{
    '{tgt: 20,  off: 0,  mean: 199},
    '{tgt: 5,   off: 3,  mean: 46},
    '{tgt: 100, off: -4, mean: 1003},
    '{tgt: 255, off: 7,  mean: 2542}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] target_code = '0;
  logic          code_valid = 1'b0;
  logic [CW-1:0] code_data = '0;
  logic          code_ready, charge_up, charge_dn, settled, out_of_range, mean_valid;
  logic [IW-1:0] integ_level, mean_level;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int adc_off = 0;
  int onehot_err = 0;

  always #4 clk = ~clk;

  boundary_servo dut (
    .clk(clk), .rst_n(rst_n), .target_code(target_code),
    .code_valid(code_valid), .code_ready(code_ready), .code_data(code_data),
    .charge_up(charge_up), .charge_dn(charge_dn), .integ_level(integ_level),
    .settled(settled), .out_of_range(out_of_range),
    .mean_level(mean_level), .mean_valid(mean_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int adc_model(input int lvl, input int off);
    int v;
    v = lvl + off;
    if (v < 0) v = 0;
    v = v / 10;
    if (v > 255) v = 255;
    return v;
  endfunction

  // one closed-loop sample: called at a negedge, drives the converter word
  task automatic feed();
    if (charge_up && charge_dn) onehot_err++;
    code_data  = CW'(adc_model(int'(integ_level), adc_off));
    code_valid = 1'b1;
  endtask

  task automatic run_loop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      feed();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first_mean, gap, hover_err;
    bit seen;
    // reset state
    repeat (3) @(negedge clk);
    chk(code_ready == 1'b0, "R1 ready low in reset", code_ready, 0);
    chk({charge_up, charge_dn} == 2'b00, "R2 drives idle after reset", {charge_up, charge_dn}, 0);
    chk(integ_level == '0, "R3 level zero after reset", integ_level, 0);
    chk(settled == 1'b0 && out_of_range == 1'b0 && mean_valid == 1'b0,
        "R6 flags clear after reset", {settled, out_of_range, mean_valid}, 0);
    target_code = 8'd3;
    rst_n = 1'b1;
    @(negedge clk);
    chk(code_ready == 1'b1, "R1 ready after reset", code_ready, 1);

    // single steps
    code_data = 8'd0; code_valid = 1'b1;
    @(negedge clk);
    code_valid = 1'b0;
    chk(integ_level == 12'd1, "R3 one unit up", integ_level, 1);
    chk(charge_up == 1'b1 && charge_dn == 1'b0, "R2 below target charges", {charge_up, charge_dn}, 2);
    code_data = 8'd200;
    repeat (3) @(negedge clk);
    chk(integ_level == 12'd1, "R9 no valid keeps level", integ_level, 1);
    chk(charge_up == 1'b1 && charge_dn == 1'b0, "R9 no valid keeps drive", {charge_up, charge_dn}, 2);
    code_data = 8'd3; code_valid = 1'b1;
    @(negedge clk);
    code_valid = 1'b0;
    chk(integ_level == 12'd0, "R3 one unit down", integ_level, 0);
    chk(charge_up == 1'b0 && charge_dn == 1'b1, "R2 equal to target discharges", {charge_up, charge_dn}, 1);
    chk(out_of_range == 1'b0, "R5 no flag inside range", out_of_range, 0);

    // table of closed-loop measurements
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      target_code = CW'(TV[k].tgt);
      adc_off = TV[k].off;
      onehot_err = 0;
      feed();
      seen = 1'b0;
      for (int c = 0; c < 8000 && !seen; c++) begin
        @(negedge clk);
        if (mean_valid) seen = 1'b1;
        feed();
      end
      chk(seen, "R7 first mean strobe", seen, 1);
      first_mean = int'(mean_level);
      chk(first_mean == TV[k].mean, "R10 mean at boundary", first_mean, TV[k].mean);
      chk(settled == 1'b1, "R6 settled while averaging", settled, 1);
      gap = 0; hover_err = 0; seen = 1'b0;
      for (int c = 0; c < 3000 && !seen; c++) begin
        @(negedge clk);
        gap++;
        if (mean_valid) seen = 1'b1;
        feed();
        if (int'(code_data) != TV[k].tgt && int'(code_data) != TV[k].tgt - 1) hover_err++;
      end
      chk(gap == 1024, "R7 samples per mean", gap, 1024);
      chk(int'(mean_level) == TV[k].mean, "R7 second mean", int'(mean_level), TV[k].mean);
      chk(hover_err == 0, "R10 hover codes", hover_err, 0);
      chk(onehot_err == 0, "R2 single drive path", onehot_err, 0);
    end

    // disturbance: long run drops settled, loop re-settles
    adc_off = 17;
    run_loop(8);
    chk(settled == 1'b0, "R6 long run drops settled", settled, 0);
    run_loop(60);
    chk(settled == 1'b1, "R6 re-settles", settled, 1);

    // top limit
    @(negedge clk);
    target_code = 8'd10;
    adc_off = -100000;
    feed();
    run_loop(100);
    chk(integ_level == 12'd2559, "R4 top saturation", integ_level, 2559);
    chk(out_of_range == 1'b1, "R5 flag at top", out_of_range, 1);
    chk(settled == 1'b0, "R6 not settled when pinned", settled, 0);

    // retarget clears, then bottom limit
    @(negedge clk);
    target_code = 8'd0;
    adc_off = 0;
    feed();
    @(negedge clk);
    chk(out_of_range == 1'b0, "R8 retarget clears flag", out_of_range, 0);
    feed();
    run_loop(2700);
    chk(integ_level == 12'd0, "R4 bottom saturation", integ_level, 0);
    chk(out_of_range == 1'b1, "R5 flag at bottom", out_of_range, 1);

    @(negedge clk);
    code_valid = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule